// File: doc/BRIEF.md
# DRAM Column Address Pin Mapper

This block takes the physical byte address of an access and places its column part onto the 13 memory-address pins of a DRAM with a 64-bit data bus. The three lowest address bits select a byte inside the 8-byte bus word and never reach the pins, so the lowest pin carries physical bit 3. A 4-bit encoded column field from the slot configuration sets how many column bits the device has. A per-access flag requests autoprecharge. That flag only appears on the pins when the column address is wide enough to reach pin 10.

Alongside the pin pattern, the block returns a 3-bit page-size code for the configured column width. It also returns a slot-off indication when the width is outside the supported range. Results are registered and are returned one cycle after an input strobe, together with an output strobe.

Top module: `col_pin_mapper`

## Requirements
- R1: While reset is held low at a clock edge, out_valid, col_addr, page_code and slot_off all become 0.
- R2: The encoded field col_raw decodes to a column count as follows: raw 7..15 gives the same count, raw 1 gives 16, raw 2 gives 17, and raw 0, 3, 4, 5 and 6 give 0.
- R3: For a column count c from 7 to 12, page_code is c-7 (0 = 1K page, 5 = 32K page) and slot_off is 0.
- R4: For any other column count, page_code is 7 and slot_off is 1. page_code never takes the value 6.
- R5: For counts 7 to 10, col_addr[c-1:0] equals phys_addr[c+2:3]. All higher pins are 0, including pin 10, whatever autopre is.
- R6: For count 11, col_addr[9:0] equals phys_addr[12:3], col_addr[10] equals autopre, col_addr[11] equals phys_addr[13], and col_addr[12] is 0.
- R7: For count 12, the count-11 layout applies and col_addr[12] equals phys_addr[14].
- R8: When slot_off is 1, col_addr is all zeros and out_valid is still returned for the access.
- R9: out_valid is 1 exactly in the cycle after a cycle with in_valid high. Without in_valid, col_addr, page_code and slot_off hold their values.
- R10: phys_addr[2:0] never affects col_addr.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Access strobe; inputs are sampled when high |
| col_raw | input | 4 | Encoded column-width field of the slot |
| autopre | input | 1 | Autoprecharge request of the access |
| phys_addr | input | PA_W | Physical byte address |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| col_addr | output | 13 | Column pattern for the memory-address pins |
| page_code | output | 3 | Page-size code; 7 marks a slot that is off |
| slot_off | output | 1 | Column width unsupported, slot treated as absent |

## Verification
The bench builds the block with a 16-bit physical address. That width covers every bit that can reach a pin (bits 3 to 14) plus the three byte-select bits and one bit above the pins, which must never appear. With the address this narrow, all 16 encoded column fields can be swept against both autoprecharge values. Each combination is driven with walking-one addresses and a strided address scan. This reaches every pin-to-bit route, the pin-10 insertion, the saturated page code, and the zeroed output of an absent slot.

// File: rtl/colmap_pkg.sv
// Shared types and the column-field decode for the column pin mapper.
// Assumes a 4-bit encoded field; counts up to 17 fit in 5 bits.
package colmap_pkg;

    typedef logic [4:0] col_count_t;
    typedef logic [2:0] page_code_t;

    localparam page_code_t PAGE_OFF = 3'd7;

    // Translate the encoded column field into a column-bit count
    function automatic col_count_t decode_cols(input logic [3:0] raw);
        col_count_t cnt;
        if (raw >= 4'd7)
            cnt = {1'b0, raw};
        else if (raw == 4'd1)
            cnt = 5'd16;
        else if (raw == 4'd2)
            cnt = 5'd17;
        else
            cnt = 5'd0;
        return cnt;
    endfunction

endpackage

// File: rtl/colmap_decode.sv
// Column-field decoder: turns the raw slot field into a column-bit count.
// Purely combinational; assumes the field is stable while in_valid is high.
module colmap_decode
    import colmap_pkg::*;
(
    input  logic [3:0] raw,
    output col_count_t count
);

    // Table lookup performed by the package function
    always_comb begin
        count = decode_cols(raw);
    end

endmodule

// File: rtl/colmap_page.sv
// Page-size helper: converts a column count into a page code, saturating to
// the off code when the count lies outside [MIN_COLS, MAX_COLS].
// Assumes MAX_COLS - MIN_COLS stays below the off code.
module colmap_page
    import colmap_pkg::*;
#(
    parameter int MIN_COLS = 7,
    parameter int MAX_COLS = 12
) (
    input  col_count_t count,
    output page_code_t code,
    output logic       off
);

    localparam col_count_t LO = col_count_t'(MIN_COLS);
    localparam col_count_t HI = col_count_t'(MAX_COLS);

    logic [4:0] diff;

    // Offset from the smallest width, or the off code when out of range
    always_comb begin
        diff = count - LO;
        off  = (count < LO) || (count > HI);
        code = off ? PAGE_OFF : diff[2:0];
    end

endmodule

// File: rtl/colmap_pins.sv
// Pin router: places physical address bits onto the column pins. Pins below
// AP_PIN carry consecutive address bits from bit SHIFT upward; AP_PIN carries
// autoprecharge once the count reaches past it; pins above it continue the
// address sequence one bit lower. Unused pins are driven to zero.
// Assumes PA_W is wide enough for the highest routed bit.
module colmap_pins
    import colmap_pkg::*;
#(
    parameter int PA_W   = 32,
    parameter int MA_W   = 13,
    parameter int AP_PIN = 10,
    parameter int SHIFT  = 3
) (
    input  logic [PA_W-1:0] pa,
    input  logic            ap,
    input  col_count_t      count,
    output logic [MA_W-1:0] ma
);

    for (genvar i = 0; i < MA_W; i++) begin : g_pin
        if (i < AP_PIN) begin : g_low
            localparam int SRC = i + SHIFT;
            if (SRC < PA_W) begin : g_src
                // Low pin: driven while the column count covers it
                always_comb ma[i] = (count > col_count_t'(i)) ? pa[SRC] : 1'b0;
            end else begin : g_nosrc
                assign ma[i] = 1'b0;
            end
        end else if (i == AP_PIN) begin : g_ap
            // Autoprecharge pin: only used when the column reaches beyond it
            always_comb ma[i] = (count > col_count_t'(AP_PIN)) ? ap : 1'b0;
        end else begin : g_high
            localparam int SRC = i + SHIFT - 1;
            if (SRC < PA_W) begin : g_src
                // High pin: skips the autoprecharge slot
                always_comb ma[i] = (count >= col_count_t'(i)) ? pa[SRC] : 1'b0;
            end else begin : g_nosrc
                assign ma[i] = 1'b0;
            end
        end
    end

endmodule

// File: rtl/col_pin_mapper.sv
// Column address pin mapper, top level. Decodes the slot's column field,
// routes the access address onto the column pins, derives the page code and
// registers the result one cycle after in_valid. An absent slot returns an
// all-zero pattern. Synchronous active-low reset.
module col_pin_mapper
    import colmap_pkg::*;
#(
    parameter int PA_W     = 32,
    parameter int MA_W     = 13,
    parameter int AP_PIN   = 10,
    parameter int SHIFT    = 3,
    parameter int MIN_COLS = 7,
    parameter int MAX_COLS = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [3:0]      col_raw,
    input  logic            autopre,
    input  logic [PA_W-1:0] phys_addr,
    output logic            out_valid,
    output logic [MA_W-1:0] col_addr,
    output logic [2:0]      page_code,
    output logic            slot_off
);

    localparam int TOP_PIN = MA_W - 1;

    col_count_t      cnt;
    page_code_t      code_c;
    logic            off_c;
    logic [MA_W-1:0] ma_c;

    colmap_decode u_dec (.raw(col_raw), .count(cnt));

    colmap_page #(.MIN_COLS(MIN_COLS), .MAX_COLS(MAX_COLS)) u_page (
        .count(cnt), .code(code_c), .off(off_c)
    );

    colmap_pins #(.PA_W(PA_W), .MA_W(MA_W), .AP_PIN(AP_PIN), .SHIFT(SHIFT)) u_pins (
        .pa(phys_addr), .ap(autopre), .count(cnt), .ma(ma_c)
    );

    // Output register: load on strobe, zero the pattern for an absent slot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            col_addr  <= '0;
            page_code <= '0;
            slot_off  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                col_addr  <= off_c ? '0 : ma_c;
                page_code <= code_c;
                slot_off  <= off_c;
            end
        end
    end

    // R9
    valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R9
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(col_addr) && $stable(page_code)));
    // R8
    off_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_off |-> (col_addr == '0));
    // R4
    off_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_off == (page_code == PAGE_OFF));
    // R4
    no_code6_chk: assert property (@(posedge clk) disable iff (!rst_n)
        page_code != 3'd6);
    // R5
    narrow_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!slot_off && page_code <= 3'd3) |-> (col_addr[TOP_PIN:AP_PIN] == '0));
    // R6
    ap_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cnt == col_count_t'(AP_PIN + 1)) |=> (col_addr[AP_PIN] == $past(autopre)));
    // R7
    top_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cnt == col_count_t'(AP_PIN + 1)) |=> !col_addr[TOP_PIN]);

endmodule

// File: tb/col_pin_mapper_test.sv
module col_pin_mapper_test;

    localparam int PA_W = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic [3:0]      col_raw = '0;
    logic            autopre = 1'b0;
    logic [PA_W-1:0] phys_addr = '0;
    logic            out_valid;
    logic [12:0]     col_addr;
    logic [2:0]      page_code;
    logic            slot_off;

    int checks = 0;
    int errors = 0;

    col_pin_mapper #(.PA_W(PA_W)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .col_raw(col_raw),
        .autopre(autopre), .phys_addr(phys_addr), .out_valid(out_valid),
        .col_addr(col_addr), .page_code(page_code), .slot_off(slot_off)
    );

    always #2 clk = ~clk;

    function automatic int exp_count(input int raw);
        if (raw >= 7) return raw;
        if (raw == 1) return 16;
        if (raw == 2) return 17;
        return 0;
    endfunction

    function automatic int exp_code(input int n);
        if (n >= 7 && n <= 12) return n - 7;
        return 7;
    endfunction

    function automatic int exp_addr(input int n, input int ap, input int pa);
        int a;
        if (n < 7 || n > 12) return 0;
        if (n <= 10) return (pa >> 3) & ((1 << n) - 1);
        a = ((pa >> 3) & 32'h3FF) | (ap << 10) | (((pa >> 13) & 1) << 11);
        if (n == 12) a = a | (((pa >> 14) & 1) << 12);
        return a;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_vec(input int raw, input int ap, input int pa);
        int n, ec, ea;
        string tag;
        n  = exp_count(raw);
        ec = exp_code(n);
        ea = exp_addr(n, ap, pa);
        if (ec == 7) tag = "R8";
        else if (n <= 10) tag = "R5";
        else if (n == 11) tag = "R6";
        else tag = "R7";
        col_raw = raw[3:0];
        autopre = ap[0];
        phys_addr = pa[PA_W-1:0];
        in_valid = 1'b1;
        @(negedge clk);
        check({tag, " valid"}, int'(out_valid), 1);
        check({tag, " addr"}, int'(col_addr), ea);
        check(ec == 7 ? "R4 code" : "R3 code", int'(page_code), ec);
        check(ec == 7 ? "R4 off" : "R3 off", int'(slot_off), ec == 7 ? 1 : 0);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        int held;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 valid", int'(out_valid), 0);
        check("R1 addr", int'(col_addr), 0);
        check("R1 code", int'(page_code), 0);
        check("R1 off", int'(slot_off), 0);
        rst_n = 1'b1;

        // R2 decode table, seen through page code
        for (int r = 0; r < 16; r++) begin
            run_vec(r, 0, 0);
            check("R2 decode", int'(page_code), exp_code(exp_count(r)));
        end

        // R10 byte-select bits never reach the pins
        for (int r = 7; r < 13; r++)
            for (int b = 0; b < 8; b++) begin
                run_vec(r, 0, b);
                check("R10 low bits", int'(col_addr), 0);
            end

        // main sweep: every field, both autoprecharge values, many addresses
        for (int r = 0; r < 16; r++)
            for (int ap = 0; ap < 2; ap++) begin
                for (int b = 0; b < PA_W; b++) run_vec(r, ap, 1 << b);
                run_vec(r, ap, (1 << PA_W) - 1);
                for (int pa = 5; pa < (1 << PA_W); pa += 149) run_vec(r, ap, pa);
            end

        // R9 hold without strobe
        run_vec(12, 1, 16'h7FF8);
        held = int'(col_addr);
        in_valid = 1'b0;
        col_raw = 4'd7;
        phys_addr = 16'h0008;
        autopre = 1'b0;
        @(negedge clk);
        check("R9 no valid", int'(out_valid), 0);
        check("R9 hold addr", int'(col_addr), held);
        check("R9 hold code", int'(page_code), 5);
        @(negedge clk);
        check("R9 still idle", int'(out_valid), 0);

        // R1 reset again clears a loaded result
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reclear addr", int'(col_addr), 0);
        check("R1 reclear valid", int'(out_valid), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule